// File: doc/BRIEF.md
# Self-Test Response Comparator

This block checks the responses of a circuit under self-test against known-good values and reduces the whole test run to one pass/fail verdict. It receives one response word per accepted beat on a valid/ready interface. Each word is compared bit by bit against an expected word, and any difference sets a sticky failure flag. The flag holds until the next test start. The block also records the index of the first failing vector.

The expected word has one of two sources, fixed by a build-time parameter. In stored-response mode, a built-in table of good responses is stepped by the vector counter, and the run ends once the last entry has been compared. In duplicate mode, the expected word comes from a second, identical copy of the circuit that is fed the same patterns. That run ends when an external end pulse arrives. A test-only force input turns any accepted beat into a mismatch, so that the failure path can itself be proven to work.

Back-pressure rules: `resp_ready` is high only while a run is in progress. A beat is taken on a rising clock edge where `resp_valid` and `resp_ready` are both high and `bist_start` is low. The sender must hold its data until that edge. Once the run has ended, `resp_ready` stays low until the next start.

Top module: `resp_cmp_checker`

## Requirements
- R1: Any bit difference between `act_bus` and the expected word on an accepted beat marks the run as failed, so `pass` is 0 once `done` is high.
- R2: A failure, once recorded, is not cleared by any later matching beat. Only `bist_start` clears it.
- R3: A cycle with `bist_start` high clears the failure flag, the vector counter, `done` and `fail_idx` to 0, and starts a run. The first comparison is the first accepted beat after that cycle.
- R4: In stored-response mode (`EXP_SRC` = 0), the expected word for vector i is (i*ROM_MUL + ROM_ADD) mod 2^WIDTH. The defaults are 37 and 11.
- R5: `fail_idx` holds the index, counted from 0 within the run, of the first mismatching beat. Later mismatches do not change it.
- R6: In stored-response mode, `done` rises the cycle after the DEPTH-th beat is accepted, and not before.
- R7: `pass` is 1 only while `done` is 1 and no failure was recorded. It is 0 whenever `done` is 0.
- R8: `resp_ready` is high only during a run. Beats presented while `resp_valid` or `resp_ready` is low have no effect on the result.
- R9: `force_mis` high on an accepted beat records a failure even when the data match.
- R10: In duplicate mode (`EXP_SRC` = 1), the expected word is `dup_bus`. `done` rises the cycle after `dup_end` is seen during a run. A beat accepted in that same cycle is still compared. `dup_end` outside a run is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bist_start | input | 1 | Clears the result and begins a run |
| resp_valid | input | 1 | Response beat valid |
| resp_ready | output | 1 | Block accepts beats (run in progress) |
| act_bus | input | WIDTH | Response word from the circuit under test |
| dup_bus | input | WIDTH | Expected word from the duplicate circuit (duplicate mode) |
| dup_end | input | 1 | End of sequence in duplicate mode |
| force_mis | input | 1 | Test-only: force the current beat to mismatch |
| pass | output | 1 | Verdict, meaningful while done is high |
| done | output | 1 | Run finished |
| fail_idx | output | $clog2(DEPTH) | Index of the first failing vector |

## Verification
The hardest case to reach from the ports is a second mismatch that arrives after the first one has already been recorded. It must leave both the flag and the frozen index untouched. The bench injects flips at two separate vector positions and in different bit positions, and then checks the index that appears when the run ends. The other awkward case is a run that is still passing while stale mismatching data sit on the bus without a handshake. The bench drives wrong words while `resp_valid` is low, and again after the run has ended while `resp_ready` is low, and expects the verdict to stay a pass. A start issued right after a failed run checks that the result fully recovers.

// File: rtl/resp_cmp_pkg.sv
package resp_cmp_pkg;
  typedef enum logic {
    SRC_ROM = 1'b0,
    SRC_DUP = 1'b1
  } exp_src_e;
endpackage

// File: rtl/rcc_exp_source.sv
module rcc_exp_source #(
  parameter int WIDTH   = 8,
  parameter int DEPTH   = 16,
  parameter int IDX_W   = 4,
  parameter bit EXP_SRC = 1'b0,
  parameter int ROM_MUL = 37,
  parameter int ROM_ADD = 11
) (
  input  logic [IDX_W-1:0] addr,
  input  logic [WIDTH-1:0] dup_bus,
  output logic [WIDTH-1:0] exp_bus
);
  import resp_cmp_pkg::*;

  generate
    if (exp_src_e'(EXP_SRC) == SRC_ROM) begin : g_rom
      logic [WIDTH-1:0] table_q [DEPTH];
      for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign table_q[g] = WIDTH'(g * ROM_MUL + ROM_ADD);
      end
      always_comb begin
        exp_bus = '0;
        for (int k = 0; k < DEPTH; k++) begin
          if (addr == IDX_W'(k)) exp_bus = table_q[k];
        end
      end
      logic dup_unused;
      assign dup_unused = ^dup_bus;
    end else begin : g_dup
      assign exp_bus = dup_bus;
      logic addr_unused;
      assign addr_unused = ^addr;
    end
  endgenerate
endmodule

// File: rtl/rcc_mismatch.sv
module rcc_mismatch #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] act_bus,
  input  logic [WIDTH-1:0] exp_bus,
  input  logic             force_mis,
  output logic             mismatch
);
  logic [WIDTH-1:0] diff;
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign diff[b] = act_bus[b] ^ exp_bus[b];
    end
  endgenerate
  assign mismatch = (|diff) | force_mis;
endmodule

// File: rtl/rcc_sequencer.sv
module rcc_sequencer #(
  parameter int DEPTH   = 16,
  parameter int IDX_W   = 4,
  parameter bit EXP_SRC = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             beat,
  input  logic             dup_end,
  output logic [IDX_W-1:0] cnt,
  output logic             running,
  output logic             done
);
  import resp_cmp_pkg::*;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic finish;
  generate
    if (exp_src_e'(EXP_SRC) == SRC_ROM) begin : g_rom_end
      assign finish = beat && (cnt == LAST);
      logic end_unused;
      assign end_unused = dup_end;
    end else begin : g_ext_end
      assign finish = running && dup_end;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      cnt     <= '0;
      running <= 1'b1;
      done    <= 1'b0;
    end else begin
      if (beat) cnt <= cnt + 1'b1;
      if (finish) begin
        running <= 1'b0;
        done    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rcc_sticky.sv
module rcc_sticky #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             beat,
  input  logic             mismatch,
  input  logic [IDX_W-1:0] cnt,
  output logic             fail_q,
  output logic [IDX_W-1:0] fail_idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q   <= 1'b0;
      fail_idx <= '0;
    end else if (start) begin
      fail_q   <= 1'b0;
      fail_idx <= '0;
    end else if (beat && mismatch && !fail_q) begin
      fail_q   <= 1'b1;
      fail_idx <= cnt;
    end
  end
endmodule

// File: rtl/resp_cmp_checker.sv
module resp_cmp_checker #(
  parameter int WIDTH   = 8,
  parameter int DEPTH   = 16,
  parameter bit EXP_SRC = 1'b0,
  parameter int ROM_MUL = 37,
  parameter int ROM_ADD = 11,
  localparam int IDX_W  = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bist_start,
  input  logic             resp_valid,
  output logic             resp_ready,
  input  logic [WIDTH-1:0] act_bus,
  input  logic [WIDTH-1:0] dup_bus,
  input  logic             dup_end,
  input  logic             force_mis,
  output logic             pass,
  output logic             done,
  output logic [IDX_W-1:0] fail_idx
);
  logic [IDX_W-1:0] cnt;
  logic [WIDTH-1:0] exp_bus;
  logic             running;
  logic             beat;
  logic             mismatch;
  logic             fail_q;

  assign resp_ready = running;
  assign beat       = resp_valid && running && !bist_start;

  rcc_exp_source #(
    .WIDTH(WIDTH), .DEPTH(DEPTH), .IDX_W(IDX_W), .EXP_SRC(EXP_SRC),
    .ROM_MUL(ROM_MUL), .ROM_ADD(ROM_ADD)
  ) u_src (
    .addr(cnt), .dup_bus(dup_bus), .exp_bus(exp_bus)
  );

  rcc_mismatch #(.WIDTH(WIDTH)) u_cmp (
    .act_bus(act_bus), .exp_bus(exp_bus), .force_mis(force_mis),
    .mismatch(mismatch)
  );

  rcc_sequencer #(.DEPTH(DEPTH), .IDX_W(IDX_W), .EXP_SRC(EXP_SRC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(bist_start), .beat(beat),
    .dup_end(dup_end), .cnt(cnt), .running(running), .done(done)
  );

  rcc_sticky #(.IDX_W(IDX_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .start(bist_start), .beat(beat),
    .mismatch(mismatch), .cnt(cnt), .fail_q(fail_q), .fail_idx(fail_idx)
  );

  assign pass = done && !fail_q;
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bist_start,
  input logic             resp_valid,
  input logic             resp_ready,
  input logic             force_mis,
  input logic             done,
  input logic             pass,
  input logic             fail_q,
  input logic [IDX_W-1:0] fail_idx
);
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !bist_start) |=> fail_q); // R2
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bist_start |=> (!fail_q && !done && fail_idx == '0)); // R3
  AST_IDX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !bist_start) |=> $stable(fail_idx)); // R5
  AST_PASS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !pass); // R7
  AST_NO_READY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !resp_ready); // R8
  AST_FORCE_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_ready && force_mis && !bist_start) |=> fail_q); // R9
endmodule

bind resp_cmp_checker rcc_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bist_start(bist_start), .resp_valid(resp_valid),
  .resp_ready(resp_ready), .force_mis(force_mis), .done(done), .pass(pass),
  .fail_q(fail_q), .fail_idx(fail_idx)
);

// File: tb/sim_resp_cmp_checker.sv
`timescale 1ns/1ps
module sim_resp_cmp_checker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // stored-response instance
  logic       a_start = 0, a_valid = 0, a_force = 0, a_ready, a_pass, a_done;
  logic [7:0] a_act = 0;
  logic [3:0] a_idx;
  // duplicate-circuit instance
  logic       b_start = 0, b_valid = 0, b_end = 0, b_ready, b_pass, b_done;
  logic [7:0] b_act = 0, b_dup = 0;
  logic [3:0] b_idx;

  resp_cmp_checker #(.WIDTH(8), .DEPTH(16), .EXP_SRC(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .bist_start(a_start), .resp_valid(a_valid),
    .resp_ready(a_ready), .act_bus(a_act), .dup_bus(8'h00), .dup_end(1'b0),
    .force_mis(a_force), .pass(a_pass), .done(a_done), .fail_idx(a_idx));

  resp_cmp_checker #(.WIDTH(8), .DEPTH(16), .EXP_SRC(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .bist_start(b_start), .resp_valid(b_valid),
    .resp_ready(b_ready), .act_bus(b_act), .dup_bus(b_dup), .dup_end(b_end),
    .force_mis(1'b0), .pass(b_pass), .done(b_done), .fail_idx(b_idx));

  function automatic logic [7:0] good_word(input int i);
    return 8'(i * 37 + 11);
  endfunction

  task automatic check(input string req, input int got, input int want);
    n_chk++;
    if (got != want) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, want);
    end
  endtask

  task automatic a_go();
    @(negedge clk); a_start = 1;
    @(negedge clk); a_start = 0;
  endtask

  task automatic a_beat(input logic [7:0] d, input logic f);
    a_act = d; a_force = f; a_valid = 1;
    @(negedge clk);
    a_valid = 0; a_force = 0;
  endtask

  // full stored-response run; bad1/bad2 flip bits, frc forces a mismatch
  task automatic a_run(input int bad1, input int bad2, input int frc, input bit gaps);
    a_go();
    for (int i = 0; i < 16; i++) begin
      logic [7:0] d;
      d = good_word(i);
      if (i == bad1) d = d ^ 8'h01;
      if (i == bad2) d = d ^ 8'h80;
      if (gaps) begin
        a_act = ~good_word(i); a_force = 1; // no valid: must be ignored
        @(negedge clk);
        a_force = 0;
      end
      a_beat(d, i == frc);
      if (i == 14) check("R6 done before last beat", a_done, 0);
    end
  endtask

  task automatic t_reset();
    check("R7 pass after reset", a_pass, 0);
    check("R3 done after reset", a_done, 0);
    check("R8 ready idle after reset", a_ready, 0);
  endtask

  task automatic t_rom_clean();
    a_run(-1, -1, -1, 1'b0);
    check("R6 done after last beat", a_done, 1);
    check("R4 clean stored run passes", a_pass, 1);
    check("R8 ready low when done", a_ready, 0);
  endtask

  task automatic t_rom_two_errors();
    a_run(5, 9, -1, 1'b0);
    check("R1 mismatch fails run", a_pass, 0);
    check("R2 failure held to end", a_done, 1);
    check("R5 first index kept", a_idx, 5);
  endtask

  task automatic t_restart();
    a_go();
    check("R3 start clears done", a_done, 0);
    check("R3 start clears index", a_idx, 0);
    for (int i = 0; i < 16; i++) a_beat(good_word(i), 1'b0);
    check("R3 rerun passes after failure", a_pass, 1);
  endtask

  task automatic t_force();
    a_run(-1, -1, 3, 1'b0);
    check("R9 force mismatch fails", a_pass, 0);
    check("R9 forced index", a_idx, 3);
  endtask

  task automatic t_ignored();
    a_run(-1, -1, -1, 1'b1);
    check("R8 no-valid junk ignored", a_pass, 1);
    a_beat(8'h00, 1'b1); // ready is low
    a_beat(8'hFF, 1'b0);
    check("R8 beats after done ignored", a_pass, 1);
    check("R8 done kept", a_done, 1);
  endtask

  task automatic t_last_beat_error();
    a_run(15, -1, -1, 1'b0);
    check("R1 last-vector mismatch", a_pass, 0);
    check("R5 last index", a_idx, 15);
  endtask

  task automatic b_beat(input logic [7:0] d, input logic [7:0] e, input logic fin);
    b_act = d; b_dup = e; b_valid = 1; b_end = fin;
    @(negedge clk);
    b_valid = 0; b_end = 0;
  endtask

  task automatic t_dup();
    @(negedge clk); b_end = 1;
    @(negedge clk); b_end = 0;
    check("R10 end outside run ignored", b_done, 0);
    @(negedge clk); b_start = 1;
    @(negedge clk); b_start = 0;
    for (int i = 0; i < 20; i++) b_beat(8'(i * 13), 8'(i * 13), 1'b0);
    check("R10 no done before end", b_done, 0);
    @(negedge clk); b_end = 1;
    @(negedge clk); b_end = 0;
    check("R10 done on end", b_done, 1);
    check("R10 matching duplicate passes", b_pass, 1);
    @(negedge clk); b_start = 1;
    @(negedge clk); b_start = 0;
    b_beat(8'h11, 8'h11, 1'b0);
    b_beat(8'h22, 8'h22, 1'b0);
    b_beat(8'h30, 8'h33, 1'b0);
    b_beat(8'h44, 8'h45, 1'b1); // end on same beat, still compared
    check("R10 mismatch vs duplicate fails", b_pass, 0);
    check("R5 duplicate first index", b_idx, 2);
    check("R10 done with final beat", b_done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rom_clean();
    t_rom_two_errors();
    t_restart();
    t_force();
    t_ignored();
    t_last_beat_error();
    t_dup();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule